// File: doc/BRIEF.md
# Wake Event Source Arbiter

This block watches four sources of wake or service requests and turns each detected event into single-cycle request pulses for the rest of the power-management logic. The sources are an asynchronous ring-indicate line, an asynchronous external power-management-event line (idle high), an internal host-controller power-management-event bit, and a sleep-button line. The current system sleep state (S0 to S5, 3-bit encoded) decides what each event may do. In S0 a ring becomes an interrupt. In S1 to S5 it becomes a wake, provided its enable is set. A sleep-button press is a request to sleep when the system is in S0. It wakes the system from S1 to S4 and is ignored from S5.

A small register interface holds the enables and the routing choices for the power-management events (SMI, SCI, wake). It also holds a sticky status word that software clears by writing 1s. The outputs are plain control pulses with no handshake: each lasts exactly one clock. All pulses caused by one event appear in the same cycle. No data stream passes through the block, so no valid/ready back-pressure applies.

Top module: `wake_arbiter`

## Requirements
- R1: While the sleep state is S0 (code 0), a ring event never raises `wake_pulse`, whatever the ring enable (control bit 0) holds.
- R2: A rising transition of the synchronised ring line in S0 raises `irq_pulse` for one cycle and sets status bit 0.
- R3: In S1 to S5 (codes 1 to 5), a ring event with control bit 0 cleared is ignored: no pulse and no status bit.
- R4: In S1 to S5, a ring event with control bit 0 set raises `wake_pulse` and sets status bit 0. The ring line is not filtered, so a level lasting a single clock counts as an event.
- R5: The external PME line, after a two-flop synchronizer, causes an event only on a high-to-low transition. A low-to-high transition does nothing.
- R6: A PME event raises `smi_pulse` when control bit 2 is set, `sci_pulse` when control bit 3 is set, and `wake_pulse` when control bit 1 is set and the state is not S0. Status bit 1 records external PME events.
- R7: A rising transition of the internal host-controller PME bit has the same routing effect as an external PME event and sets its own status bit 2.
- R8: With control bit 4 set, a rising sleep-button transition in S0 raises `sleep_req_pulse` and sets status bit 3. With bit 4 clear, the press does nothing.
- R9: With control bit 4 set, a sleep-button press in S1 to S4 raises `wake_pulse`. In S5, and in the unused codes 6 and 7, the press does nothing.
- R10: Status bits are sticky. Writing a 1 to a bit at register address 1 clears it, and writing 0 leaves it unchanged. Address 0 holds the control bits [4:0].
- R11: After reset, all pulse outputs are 0 and both registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_state | input | 3 | Current sleep state, 0 = S0, 1..5 = S1..S5 |
| ring_in | input | 1 | Ring indicate, asynchronous, active high |
| pme_ext_n | input | 1 | External PME, asynchronous, idle high |
| pme_hc | input | 1 | Internal host-controller PME bit |
| sleep_btn | input | 1 | Sleep button, synchronous, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control, 1 = status |
| reg_wdata | input | 5 | Write data |
| reg_rdata | output | 5 | Read data of the addressed register |
| wake_pulse | output | 1 | Wake request pulse |
| irq_pulse | output | 1 | Break-event interrupt pulse |
| smi_pulse | output | 1 | SMI request pulse |
| sci_pulse | output | 1 | SCI request pulse |
| sleep_req_pulse | output | 1 | Sleep request pulse |

## Verification
The ring line is exercised in S0 with its enable set, and in S3 and S5 with the enable clear and set. It is also given a one-clock pulse. Together these separate the interrupt path from the wake path and show that no filter swallows short pulses. The PME line is driven both down and up under each routing choice, in S0 and in a sleeping state. This separates edge from level detection and shows the state gating of the wake route. The host-controller bit confirms that a second source reaches the same routing. Sleep-button presses in S0, S4, S5 and code 7, with the enable on and off, separate the sleep request from the wake and from the deliberate S5 refusal. Status reads with 1 and 0 writes check the clear-on-one behaviour.

// File: rtl/wake_arb_pkg.sv
package wake_arb_pkg;
  localparam int STATE_W = 3;
  localparam int CTRL_W  = 5;
  localparam int STS_W   = 4;

  // control bit positions
  localparam int C_RING_EN  = 0;
  localparam int C_PME_WAKE = 1;
  localparam int C_PME_SMI  = 2;
  localparam int C_PME_SCI  = 3;
  localparam int C_BTN_EN   = 4;

  // status bit positions
  localparam int S_RING = 0;
  localparam int S_PME  = 1;
  localparam int S_HC   = 2;
  localparam int S_BTN  = 3;

  typedef struct packed {
    logic wake;
    logic irq;
    logic smi;
    logic sci;
    logic slp_req;
  } req_t;

  function automatic logic st_is_s0(input logic [STATE_W-1:0] s);
    return s == '0;
  endfunction

  function automatic logic st_is_light(input logic [STATE_W-1:0] s);
    return (s >= 3'd1) && (s <= 3'd4);
  endfunction
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int   STAGES  = 2,
  parameter bit   FALL    = 1'b0,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic edge_det
);
  logic lvl;
  logic prev;

  generate
    if (STAGES == 0) begin : g_direct
      assign lvl = async_in;
    end else begin : g_chain
      logic [STAGES-1:0] ff;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ff <= {STAGES{RST_VAL}};
        end else begin
          ff[0] <= async_in;
          for (int i = 1; i < STAGES; i++) ff[i] <= ff[i-1];
        end
      end
      assign lvl = ff[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_VAL;
    else        prev <= lvl;
  end

  generate
    if (FALL) begin : g_fall
      assign edge_det = prev & ~lvl;
    end else begin : g_rise
      assign edge_det = lvl & ~prev;
    end
  endgenerate

  // R4
  edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_det |=> !edge_det);
endmodule

// File: rtl/wake_regs.sv
module wake_regs
  import wake_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [CTRL_W-1:0] reg_wdata,
  input  logic [STS_W-1:0]  sts_set,
  output logic [CTRL_W-1:0] ctrl,
  output logic [CTRL_W-1:0] reg_rdata
);
  localparam int PAD_W = CTRL_W - STS_W;

  logic [STS_W-1:0] sts;
  logic [STS_W-1:0] clr;

  assign clr = (reg_wr && reg_addr) ? reg_wdata[STS_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      sts  <= '0;
    end else begin
      if (reg_wr && !reg_addr) ctrl <= reg_wdata;
      sts <= (sts & ~clr) | sts_set;
    end
  end

  assign reg_rdata = reg_addr ? {{PAD_W{1'b0}}, sts} : ctrl;

  // R10
  sts_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(sts) & ~$past(clr))) |-> ((sts & $past(sts) & ~$past(clr)) == ($past(sts) & ~$past(clr))));
endmodule

// File: rtl/wake_policy.sv
module wake_policy
  import wake_arb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STATE_W-1:0] sleep_state,
  input  logic [CTRL_W-1:0]  ctrl,
  input  logic               ring_edge,
  input  logic               pme_ext_edge,
  input  logic               pme_hc_edge,
  input  logic               btn_edge,
  output req_t               req_q,
  output logic [STS_W-1:0]   sts_set
);
  logic s0, light;
  logic pme_any;
  logic ring_irq, ring_wake, pme_wake, btn_req, btn_wake;
  req_t req_d;

  always_comb begin
    s0        = st_is_s0(sleep_state);
    light     = st_is_light(sleep_state);
    pme_any   = pme_ext_edge | pme_hc_edge;
    ring_irq  = ring_edge & s0;
    ring_wake = ring_edge & ~s0 & ctrl[C_RING_EN];
    pme_wake  = pme_any & ~s0 & ctrl[C_PME_WAKE];
    btn_req   = btn_edge & s0 & ctrl[C_BTN_EN];
    btn_wake  = btn_edge & light & ctrl[C_BTN_EN];

    req_d.wake    = ring_wake | pme_wake | btn_wake;
    req_d.irq     = ring_irq;
    req_d.smi     = pme_any & ctrl[C_PME_SMI];
    req_d.sci     = pme_any & ctrl[C_PME_SCI];
    req_d.slp_req = btn_req;

    sts_set         = '0;
    sts_set[S_RING] = ring_irq | ring_wake;
    sts_set[S_PME]  = pme_ext_edge;
    sts_set[S_HC]   = pme_hc_edge;
    sts_set[S_BTN]  = btn_req | btn_wake;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_d;
  end

  // R1
  ring_no_wake_s0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ring_edge) && !$past(pme_any) && !$past(btn_edge) && $past(s0)) |-> !req_q.wake);
  // R2
  irq_only_s0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_q.irq |-> $past(s0));
  // R6
  smi_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_q.smi |-> ($past(ctrl[C_PME_SMI]) && $past(pme_any)));
  // R8
  slpreq_s0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_q.slp_req |-> $past(s0));
  // R9
  btn_no_deep_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(btn_edge) && !$past(ring_edge) && !$past(pme_any) && !$past(s0) && !$past(light))
      |-> !req_q.wake);
endmodule

// File: rtl/wake_arbiter.sv
module wake_arbiter
  import wake_arb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STATE_W-1:0] sleep_state,
  input  logic               ring_in,
  input  logic               pme_ext_n,
  input  logic               pme_hc,
  input  logic               sleep_btn,
  input  logic               reg_wr,
  input  logic               reg_addr,
  input  logic [CTRL_W-1:0]  reg_wdata,
  output logic [CTRL_W-1:0]  reg_rdata,
  output logic               wake_pulse,
  output logic               irq_pulse,
  output logic               smi_pulse,
  output logic               sci_pulse,
  output logic               sleep_req_pulse
);
  logic ring_edge, pme_ext_edge, pme_hc_edge, btn_edge;
  logic [CTRL_W-1:0] ctrl;
  logic [STS_W-1:0]  sts_set;
  req_t req_q;

  wake_sync #(.STAGES(SYNC_STAGES), .FALL(1'b0), .RST_VAL(1'b0)) u_ring (
    .clk(clk), .rst_n(rst_n), .async_in(ring_in), .edge_det(ring_edge));

  wake_sync #(.STAGES(SYNC_STAGES), .FALL(1'b1), .RST_VAL(1'b1)) u_pme (
    .clk(clk), .rst_n(rst_n), .async_in(pme_ext_n), .edge_det(pme_ext_edge));

  wake_sync #(.STAGES(0), .FALL(1'b0), .RST_VAL(1'b0)) u_hc (
    .clk(clk), .rst_n(rst_n), .async_in(pme_hc), .edge_det(pme_hc_edge));

  wake_sync #(.STAGES(0), .FALL(1'b0), .RST_VAL(1'b0)) u_btn (
    .clk(clk), .rst_n(rst_n), .async_in(sleep_btn), .edge_det(btn_edge));

  wake_policy u_policy (
    .clk(clk), .rst_n(rst_n), .sleep_state(sleep_state), .ctrl(ctrl),
    .ring_edge(ring_edge), .pme_ext_edge(pme_ext_edge), .pme_hc_edge(pme_hc_edge),
    .btn_edge(btn_edge), .req_q(req_q), .sts_set(sts_set));

  wake_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .sts_set(sts_set), .ctrl(ctrl), .reg_rdata(reg_rdata));

  assign wake_pulse      = req_q.wake;
  assign irq_pulse       = req_q.irq;
  assign smi_pulse       = req_q.smi;
  assign sci_pulse       = req_q.sci;
  assign sleep_req_pulse = req_q.slp_req;

  // R11
  pulses_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !(wake_pulse | irq_pulse | smi_pulse | sci_pulse | sleep_req_pulse));
endmodule

// File: tb/wake_arbiter_bench.sv
module wake_arbiter_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] E_WAKE = 5'b10000;
  localparam logic [4:0] E_IRQ  = 5'b01000;
  localparam logic [4:0] E_SMI  = 5'b00100;
  localparam logic [4:0] E_SCI  = 5'b00010;
  localparam logic [4:0] E_SLP  = 5'b00001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] sleep_state = 3'd0;
  logic ring_in = 1'b0, pme_ext_n = 1'b1, pme_hc = 1'b0, sleep_btn = 1'b0;
  logic reg_wr = 1'b0, reg_addr = 1'b0;
  logic [4:0] reg_wdata = '0;
  logic [4:0] reg_rdata;
  logic wake_pulse, irq_pulse, smi_pulse, sci_pulse, sleep_req_pulse;

  int compared = 0, mismatched = 0;
  bit done = 1'b0;
  logic [4:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_arbiter u_wake_arbiter (
    .clk(clk), .rst_n(rst_n), .sleep_state(sleep_state), .ring_in(ring_in),
    .pme_ext_n(pme_ext_n), .pme_hc(pme_hc), .sleep_btn(sleep_btn),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wake_pulse(wake_pulse), .irq_pulse(irq_pulse), .smi_pulse(smi_pulse),
    .sci_pulse(sci_pulse), .sleep_req_pulse(sleep_req_pulse));

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] expv);
    compared++;
    if (act !== expv) begin
      mismatched++;
      $display("FAIL %s: actual %b expected %b", tag, act, expv);
    end
  endtask

  // monitor: pops expected pulse sets as the design emits them
  always @(negedge clk) begin
    logic [4:0] got;
    got = {wake_pulse, irq_pulse, smi_pulse, sci_pulse, sleep_req_pulse};
    if (rst_n && got != 5'b0) begin
      if (exp_q.size() == 0) begin
        check("unexpected pulse", got, 5'b0);
      end else begin
        check(tag_q.pop_front(), got, exp_q.pop_front());
        void'(exp_q.pop_front());
      end
    end
  end

  task automatic expect_ev(input logic [4:0] code, input string tag);
    if (code != 5'b0) begin
      exp_q.push_back(code);
      exp_q.push_back(code);
      tag_q.push_back(tag);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [4:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(input logic a, input logic [4:0] expv, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, expv);
  endtask

  task automatic ring_pulse(input int len, input logic [4:0] code, input string tag);
    expect_ev(code, tag);
    @(negedge clk); ring_in = 1'b1;
    idle(len);
    ring_in = 1'b0;
    idle(8);
  endtask

  task automatic pme_fall(input logic [4:0] code, input string tag);
    expect_ev(code, tag);
    @(negedge clk); pme_ext_n = 1'b0;
    idle(8);
  endtask

  task automatic pme_rise(input string tag);
    @(negedge clk); pme_ext_n = 1'b1;
    idle(8);
    check(tag, {4'b0, exp_q.size() != 0}, 5'b0);
  endtask

  task automatic hc_toggle(input logic [4:0] code, input string tag);
    expect_ev(code, tag);
    @(negedge clk); pme_hc = 1'b1;
    idle(4);
    pme_hc = 1'b0;
    idle(6);
  endtask

  task automatic btn_press(input logic [4:0] code, input string tag);
    expect_ev(code, tag);
    @(negedge clk); sleep_btn = 1'b1;
    idle(3);
    sleep_btn = 1'b0;
    idle(6);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 outputs", {wake_pulse, irq_pulse, smi_pulse, sci_pulse, sleep_req_pulse}, 5'b0);
    rd_check(1'b0, 5'h00, "R11 ctrl");
    rd_check(1'b1, 5'h00, "R11 status");

    // R1 R2: ring in S0 with enable set -> interrupt only
    wr(1'b0, 5'h01);
    sleep_state = 3'd0;
    ring_pulse(4, E_IRQ, "R1 R2 ring in S0");
    rd_check(1'b1, 5'h01, "R2 ring status");
    wr(1'b1, 5'h01);
    rd_check(1'b1, 5'h00, "R10 clear ring status");

    // R3: ring in S3, enable clear
    wr(1'b0, 5'h00);
    sleep_state = 3'd3;
    ring_pulse(4, 5'b0, "R3 ring ignored");
    rd_check(1'b1, 5'h00, "R3 no status");

    // R4: ring enable set, S3 and S5 with a one-clock pulse
    wr(1'b0, 5'h01);
    ring_pulse(4, E_WAKE, "R4 ring wake S3");
    sleep_state = 3'd5;
    ring_pulse(1, E_WAKE, "R4 short ring wake S5");
    rd_check(1'b1, 5'h01, "R4 ring status");
    wr(1'b1, 5'h01);

    // R5 R6: external PME
    wr(1'b0, 5'h04);
    sleep_state = 3'd0;
    pme_fall(E_SMI, "R5 R6 pme fall to SMI");
    pme_rise("R5 rising edge ignored");
    wr(1'b0, 5'h0A);
    sleep_state = 3'd2;
    pme_fall(E_WAKE | E_SCI, "R6 pme wake and SCI in S2");
    pme_rise("R5 rising edge ignored S2");
    sleep_state = 3'd0;
    pme_fall(E_SCI, "R6 no wake in S0");
    pme_rise("R5 rising edge ignored again");
    rd_check(1'b1, 5'h02, "R6 pme status");
    wr(1'b1, 5'h00);
    rd_check(1'b1, 5'h02, "R10 zero write keeps status");
    wr(1'b1, 5'h02);
    rd_check(1'b1, 5'h00, "R10 clear pme status");

    // R7: host-controller PME bit
    wr(1'b0, 5'h04);
    hc_toggle(E_SMI, "R7 hc pme to SMI");
    rd_check(1'b1, 5'h04, "R7 hc status");
    wr(1'b1, 5'h04);

    // R8 R9: sleep button
    wr(1'b0, 5'h10);
    sleep_state = 3'd0;
    btn_press(E_SLP, "R8 sleep request in S0");
    sleep_state = 3'd4;
    btn_press(E_WAKE, "R9 button wake from S4");
    sleep_state = 3'd5;
    btn_press(5'b0, "R9 no wake from S5");
    sleep_state = 3'd7;
    btn_press(5'b0, "R9 no wake code 7");
    rd_check(1'b1, 5'h08, "R8 button status");
    wr(1'b1, 5'h08);
    wr(1'b0, 5'h00);
    sleep_state = 3'd0;
    btn_press(5'b0, "R8 disabled button");
    rd_check(1'b1, 5'h00, "R8 disabled no status");

    idle(10);
    check("leftover expected events", {4'b0, exp_q.size() != 0}, 5'b0);
    finish_run();
  end
endmodule